// File: doc/BRIEF.md
# Serial EEPROM Write Guard and Status Unit

This unit sits beside the command engine of a small serial EEPROM. It holds the write-enable latch and the two nonvolatile protection-level bits. From these it decides, every cycle, whether an array write or a status-register write may go ahead. The command engine gives it single-cycle strobes for the instructions it has decoded: latch set, latch clear, array write issued, and status write issued. It also passes on the level of the hardware guard pin, the target address, and the busy flag of the self-timed programming cycle. In return the unit supplies the status byte that a status read shifts out, plus two permit flags.

The hardware guard pin is active low. While the pin is low, the latch is held clear and both permits are refused. While the pin is high, the latch gates all writes. The protection level then fences off none, the top quarter, the top half, or the whole of the 512-byte array. The address used for this check is the page captured when the command engine loads the target. A new protection level is held pending and takes effect only when the programming cycle that wrote it finishes.

Top module: `eewp_status_unit`

## Requirements
- R1: `status_byte` has bits 7..4 at 0, bit 3 and bit 2 holding the protection level (bit 3 the upper bit), bit 1 holding the write-enable latch, and bit 0 equal to `busy` in the same cycle.
- R2: While `rst` is high, and in the first cycle after it, `status_byte` is 0 apart from bit 0 and both permits are 0.
- R3: `array_wr_ok` is 1 exactly when `hw_guard_n` is 1, the latch is 1, `busy` is 0, and the captured page is outside the protected range. The range is set by the protection level: 00 protects nothing, 01 protects 180h–1FFh, 10 protects 100h–1FFh, and 11 protects 000h–1FFh.
- R4: The page (address bits 8..4) is captured only on a cycle with `addr_load` high. A change of `tgt_addr` without `addr_load` leaves `array_wr_ok` unchanged.
- R5: `status_wr_ok` is 1 exactly when `hw_guard_n` is 1, the latch is 1 and `busy` is 0.
- R6: A `latch_set` pulse with `hw_guard_n` high sets the latch, visible the next cycle. A `latch_clr` pulse clears it. When both arrive together, clear wins.
- R7: While `hw_guard_n` is low, the latch is cleared at the next edge and held at 0, and `latch_set` has no effect.
- R8: An `arr_write_go` pulse in a cycle with `array_wr_ok` high clears the latch. In a cycle with `array_wr_ok` low, the pulse leaves the latch unchanged.
- R9: A `stat_write_go` pulse in a cycle with `status_wr_ok` high clears the latch and holds `stat_wdata[3:2]` as the pending level. The level bits keep their old value until the first edge at which `busy` is seen low after being high; that edge loads them. A pulse while `status_wr_ok` is low records nothing.
- R10: `hw_guard_n` going low while `busy` is high does not cancel a pending level update.
- R11: `latch_set` and `latch_clr` act on the latch whatever the protection level, including level 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_guard_n | input | 1 | Hardware write guard pin level, low blocks writes |
| latch_set | input | 1 | Pulse: a valid set-latch instruction completed |
| latch_clr | input | 1 | Pulse: a valid clear-latch instruction completed |
| arr_write_go | input | 1 | Pulse: the engine is starting an array write cycle |
| stat_write_go | input | 1 | Pulse: the engine is starting a status write cycle |
| stat_wdata | input | 8 | Status write data byte, bits 3..2 give the new level |
| addr_load | input | 1 | Capture the page of `tgt_addr` |
| tgt_addr | input | 9 | Target array address from the engine |
| busy | input | 1 | Programming cycle in progress |
| status_byte | output | 8 | Status byte for a status read |
| array_wr_ok | output | 1 | Array write permitted at the captured page |
| status_wr_ok | output | 1 | Status write permitted |

## Verification
Latch and page capture are one-register paths, so a strobe or load shows on the outputs one cycle later. The permit flags and the busy bit of the status byte follow `busy` and `hw_guard_n` in the same cycle. A new protection level appears one cycle after the first cycle in which `busy` is low again. The bench drives inputs just after the falling edge and compares every output against a behavioural model at each falling edge. The directed probes, each aimed at one timing case, are placed one falling edge after the stimulus they test.

// File: rtl/eewp_pkg.sv
package eewp_pkg;

    // Protection level; the binary code is the value written in bits 3..2.
    typedef enum logic [1:0] {
        PROT_NONE = 2'b00,
        PROT_QTR  = 2'b01,
        PROT_HALF = 2'b10,
        PROT_ALL  = 2'b11
    } prot_lvl_e;

    typedef struct packed {
        logic [3:0] rsvd;
        prot_lvl_e  lvl;
        logic       wel;
        logic       wip;
    } stat_byte_t;

    // True when the two top address bits fall inside the fenced range.
    function automatic logic lvl_covers(prot_lvl_e lvl, logic [1:0] top2);
        case (lvl)
            PROT_NONE: return 1'b0;
            PROT_QTR:  return (top2 == 2'b11);
            PROT_HALF: return top2[1];
            default:   return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/eewp_wel_latch.sv
module eewp_wel_latch (
    input  logic clk,
    input  logic rst,
    input  logic guard_n,
    input  logic set_req,
    input  logic clr_req,
    output logic wel
);

    always_ff @(posedge clk) begin
        if (rst)           wel <= 1'b0;
        else if (!guard_n) wel <= 1'b0;
        else if (clr_req)  wel <= 1'b0;
        else if (set_req)  wel <= 1'b1;
    end

    assert_guard_clears_R7: assert property (@(posedge clk) disable iff (rst)
        !guard_n |=> !wel);

    assert_set_takes_R6: assert property (@(posedge clk) disable iff (rst)
        (guard_n && set_req && !clr_req) |=> wel);

    assert_clear_wins_R6: assert property (@(posedge clk) disable iff (rst)
        clr_req |=> !wel);

endmodule

// File: rtl/eewp_level_store.sv
module eewp_level_store
    import eewp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      accept,
    input  prot_lvl_e new_lvl,
    input  logic      busy,
    output prot_lvl_e lvl
);

    logic      busy_q;
    logic      pend_v;
    prot_lvl_e pend;
    logic      apply;

    assign apply = busy_q && !busy && pend_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            pend_v <= 1'b0;
            pend   <= PROT_NONE;
            lvl    <= PROT_NONE;
        end else begin
            busy_q <= busy;
            if (apply) lvl <= pend;
            if (accept) begin
                pend   <= new_lvl;
                pend_v <= 1'b1;
            end else if (apply) begin
                pend_v <= 1'b0;
            end
        end
    end

    assert_level_held_R9: assert property (@(posedge clk) disable iff (rst)
        !apply |=> $stable(lvl));

    assert_level_loads_R10: assert property (@(posedge clk) disable iff (rst)
        apply |=> (lvl == $past(pend)));

endmodule

// File: rtl/eewp_permit.sv
module eewp_permit
    import eewp_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic              guard_n,
    input  logic              wel,
    input  logic              busy,
    input  prot_lvl_e         lvl,
    output logic              array_ok,
    output logic              status_ok
);

    localparam int PG_W = ADDR_W - PAGE_W;

    logic [PG_W-1:0] pg_q;
    logic [1:0]      top2;
    logic            unused_bits;

    always_ff @(posedge clk) begin
        if (rst)            pg_q <= '0;
        else if (addr_load) pg_q <= tgt_addr[ADDR_W-1:PAGE_W];
    end

    generate
        if (PG_W >= 2) begin : g_wide
            assign top2 = pg_q[PG_W-1 -: 2];
        end else begin : g_narrow
            assign top2 = {pg_q[0], 1'b0};
        end
    endgenerate

    assign unused_bits = ^{tgt_addr[PAGE_W-1:0], pg_q};

    assign status_ok = guard_n && wel && !busy;
    assign array_ok  = status_ok && !lvl_covers(lvl, top2);

    assert_array_implies_status_R3: assert property (@(posedge clk) disable iff (rst)
        array_ok |-> status_ok);

    assert_no_latch_no_status_R5: assert property (@(posedge clk) disable iff (rst)
        !wel |-> !status_ok);

    assert_all_fenced_R3: assert property (@(posedge clk) disable iff (rst)
        (lvl == PROT_ALL) |-> !array_ok);

endmodule

// File: rtl/eewp_status_unit.sv
module eewp_status_unit
    import eewp_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hw_guard_n,
    input  logic              latch_set,
    input  logic              latch_clr,
    input  logic              arr_write_go,
    input  logic              stat_write_go,
    input  logic [7:0]        stat_wdata,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic              busy,
    output logic [7:0]        status_byte,
    output logic              array_wr_ok,
    output logic              status_wr_ok
);

    logic       wel;
    prot_lvl_e  lvl;
    logic       acc_arr;
    logic       acc_stat;
    stat_byte_t sb;
    logic       unused_wdata;

    assign acc_arr  = arr_write_go && array_wr_ok;
    assign acc_stat = stat_write_go && status_wr_ok;
    assign unused_wdata = ^{stat_wdata[7:4], stat_wdata[1:0]};

    eewp_wel_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .guard_n (hw_guard_n),
        .set_req (latch_set),
        .clr_req (latch_clr || acc_arr || acc_stat),
        .wel     (wel)
    );

    eewp_level_store u_levels (
        .clk     (clk),
        .rst     (rst),
        .accept  (acc_stat),
        .new_lvl (prot_lvl_e'(stat_wdata[3:2])),
        .busy    (busy),
        .lvl     (lvl)
    );

    eewp_permit #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_permit (
        .clk       (clk),
        .rst       (rst),
        .addr_load (addr_load),
        .tgt_addr  (tgt_addr),
        .guard_n   (hw_guard_n),
        .wel       (wel),
        .busy      (busy),
        .lvl       (lvl),
        .array_ok  (array_wr_ok),
        .status_ok (status_wr_ok)
    );

    assign sb = '{rsvd: 4'b0000, lvl: lvl, wel: wel, wip: busy};
    assign status_byte = sb;

    assert_array_write_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (arr_write_go && array_wr_ok) |=> !status_byte[1]);

    assert_status_write_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (stat_write_go && status_wr_ok) |=> !status_byte[1]);

    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (rst)
        status_byte[7:4] == 4'b0000);

endmodule

// File: tb/eewp_status_unit_bench.sv
`timescale 1ns/100ps
module eewp_status_unit_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hw_guard_n = 1'b1;
    logic       latch_set = 1'b0, latch_clr = 1'b0;
    logic       arr_write_go = 1'b0, stat_write_go = 1'b0;
    logic [7:0] stat_wdata = 8'h00;
    logic       addr_load = 1'b0;
    logic [8:0] tgt_addr = 9'h000;
    logic       busy = 1'b0;
    logic [7:0] status_byte;
    logic       array_wr_ok, status_wr_ok;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    eewp_status_unit u_eewp_status_unit (
        .clk(clk), .rst(rst), .hw_guard_n(hw_guard_n),
        .latch_set(latch_set), .latch_clr(latch_clr),
        .arr_write_go(arr_write_go), .stat_write_go(stat_write_go),
        .stat_wdata(stat_wdata), .addr_load(addr_load), .tgt_addr(tgt_addr),
        .busy(busy), .status_byte(status_byte),
        .array_wr_ok(array_wr_ok), .status_wr_ok(status_wr_ok)
    );

    // Behavioural reference model
    int m_wel = 0, m_bp = 0, m_pend = 0, m_pv = 0, m_bq = 0, m_addr = 0;

    function automatic int fenced(int bp, int addr);
        if (bp == 3) return 1;
        if (bp == 2) return (addr >= 256) ? 1 : 0;
        if (bp == 1) return (addr >= 384) ? 1 : 0;
        return 0;
    endfunction

    function automatic int exp_st_ok();
        return (hw_guard_n && m_wel != 0 && !busy) ? 1 : 0;
    endfunction

    function automatic int exp_arr_ok();
        return (exp_st_ok() != 0 && fenced(m_bp, m_addr) == 0) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        int acc_a, acc_s;
        if (rst) begin
            m_wel = 0; m_bp = 0; m_pend = 0; m_pv = 0; m_bq = 0; m_addr = 0;
        end else begin
            acc_a = (arr_write_go && exp_arr_ok() != 0) ? 1 : 0;
            acc_s = (stat_write_go && exp_st_ok() != 0) ? 1 : 0;
            if (!hw_guard_n) m_wel = 0;
            else if (latch_clr || acc_a != 0 || acc_s != 0) m_wel = 0;
            else if (latch_set) m_wel = 1;
            if (m_bq != 0 && !busy && m_pv != 0) begin
                m_bp = m_pend; m_pv = 0;
            end
            if (acc_s != 0) begin
                m_pend = int'(stat_wdata[3:2]); m_pv = 1;
            end
            if (addr_load) m_addr = int'(tgt_addr) & 9'h1F0;
            m_bq = busy ? 1 : 0;
        end
    end

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        chk("R1 reserved+busy bits", int'({status_byte[7:4], status_byte[0]}), int'({4'b0000, busy}));
        chk("R9 level bits", int'(status_byte[3:2]), m_bp);
        chk("R6 latch bit", int'(status_byte[1]), m_wel);
        chk("R3 array permit", int'(array_wr_ok), exp_arr_ok());
        chk("R5 status permit", int'(status_wr_ok), exp_st_ok());
    end

    task automatic cyc();
        @(negedge clk); #1;
    endtask

    task automatic pulse_set();
        latch_set = 1'b1; cyc(); latch_set = 1'b0;
    endtask

    task automatic pulse_clr();
        latch_clr = 1'b1; cyc(); latch_clr = 1'b0;
    endtask

    task automatic load(input logic [8:0] a);
        tgt_addr = a; addr_load = 1'b1; cyc(); addr_load = 1'b0;
    endtask

    task automatic busy_run(input int n);
        busy = 1'b1;
        for (int i = 0; i < n; i++) cyc();
        busy = 1'b0; cyc();
    endtask

    task automatic stat_write(input logic [7:0] d);
        stat_wdata = d; stat_write_go = 1'b1; cyc(); stat_write_go = 1'b0;
        busy_run(3);
    endtask

    initial begin
        #200000;
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cyc(); cyc(); cyc();
        chk("R2 reset status", int'(status_byte), 0);
        chk("R2 reset array permit", int'(array_wr_ok), 0);
        chk("R2 reset status permit", int'(status_wr_ok), 0);
        rst = 1'b0; cyc();
        chk("R2 after reset", int'(status_byte), 0);

        pulse_set();
        chk("R6 set", int'(status_byte[1]), 1);
        chk("R5 permit with latch", int'(status_wr_ok), 1);
        latch_set = 1'b1; latch_clr = 1'b1; cyc(); latch_set = 1'b0; latch_clr = 1'b0;
        chk("R6 clear wins", int'(status_byte[1]), 0);

        pulse_set();
        busy = 1'b1; cyc();
        chk("R1 busy byte", int'(status_byte), 8'h03);
        chk("R5 busy blocks", int'(status_wr_ok), 0);
        busy = 1'b0; cyc();

        load(9'h1F0);
        chk("R3 level 00 any page", int'(array_wr_ok), 1);
        arr_write_go = 1'b1; cyc(); arr_write_go = 1'b0;
        chk("R8 accepted write clears", int'(status_byte[1]), 0);
        busy_run(3);

        // level 01
        pulse_set();
        stat_wdata = 8'hF5; stat_write_go = 1'b1; cyc(); stat_write_go = 1'b0;
        busy = 1'b1; cyc();
        chk("R9 level held while busy", int'(status_byte[3:2]), 0);
        chk("R9 latch cleared by status write", int'(status_byte[1]), 0);
        cyc(); busy = 1'b0; cyc();
        chk("R9 level loaded after busy", int'(status_byte[3:2]), 1);
        chk("R1 upper bits zero", int'(status_byte[7:4]), 0);

        pulse_set();
        chk("R3 180h-1FFh fenced", int'(array_wr_ok), 0);
        arr_write_go = 1'b1; cyc(); arr_write_go = 1'b0;
        chk("R8 refused write keeps latch", int'(status_byte[1]), 1);
        load(9'h170);
        chk("R3 below quarter open", int'(array_wr_ok), 1);
        tgt_addr = 9'h1C0; cyc();
        chk("R4 no load no change", int'(array_wr_ok), 1);
        load(9'h180);
        chk("R3 quarter start fenced", int'(array_wr_ok), 0);

        // level 10
        stat_write(8'h08);
        pulse_set();
        load(9'h100);
        chk("R3 half fenced", int'(array_wr_ok), 0);
        load(9'h0F0);
        chk("R3 below half open", int'(array_wr_ok), 1);

        // level 11
        stat_write(8'h0C);
        chk("R9 level 11", int'(status_byte[3:2]), 3);
        pulse_set();
        load(9'h000);
        chk("R3 all fenced", int'(array_wr_ok), 0);
        pulse_clr();
        chk("R11 clear at level 11", int'(status_byte[1]), 0);
        pulse_set();
        chk("R11 set at level 11", int'(status_byte[1]), 1);

        // guard pin low
        hw_guard_n = 1'b0; cyc();
        chk("R7 guard clears latch", int'(status_byte[1]), 0);
        chk("R7 guard blocks status", int'(status_wr_ok), 0);
        pulse_set();
        chk("R7 set ignored under guard", int'(status_byte[1]), 0);
        hw_guard_n = 1'b1; cyc();

        // guard drop during a status cycle
        pulse_set();
        stat_wdata = 8'h00; stat_write_go = 1'b1; cyc(); stat_write_go = 1'b0;
        busy = 1'b1; cyc(); hw_guard_n = 1'b0; cyc(); busy = 1'b0; cyc();
        chk("R10 level still loaded", int'(status_byte[3:2]), 0);
        hw_guard_n = 1'b1; cyc();

        // refused status write records nothing
        stat_write(8'h0C);
        chk("R9 refused status write", int'(status_byte[3:2]), 0);

        // mixed traffic
        for (int i = 0; i < 3000; i++) begin
            hw_guard_n    = ($urandom_range(0, 9) != 0);
            latch_set     = ($urandom_range(0, 4) == 0);
            latch_clr     = ($urandom_range(0, 14) == 0);
            arr_write_go  = ($urandom_range(0, 6) == 0);
            stat_write_go = ($urandom_range(0, 7) == 0);
            stat_wdata    = 8'($urandom);
            addr_load     = ($urandom_range(0, 3) == 0);
            tgt_addr      = 9'($urandom);
            if ($urandom_range(0, 5) == 0) busy = ~busy;
            cyc();
        end
        hw_guard_n = 1'b1; latch_set = 1'b0; latch_clr = 1'b0;
        arr_write_go = 1'b0; stat_write_go = 1'b0; addr_load = 1'b0; busy = 1'b0;
        cyc(); cyc();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule